// File: doc/BRIEF.md
# Parallel Port Channel Data Path

This block is the data side of one parallel port channel of configurable width. A processor writes and reads a data register through a simple strobed interface. The channel latches written bytes, presents them on the port with a one-cycle valid pulse, samples the port pins on reads, and runs a ready line that tells the attached peripheral when a transfer has happened. A separate control sequencer supplies the operating mode and a per-bit direction mask. The peripheral's own strobe input gates both sampling and driving.

Four modes are supported: output, input, bidirectional and bit-control. They differ in three ways: whether a write reaches the pins, what a read returns, and whether the ready line pulses. In bit-control mode each bit is an input or an output according to the direction mask, and a read merges pin bits with output latch bits. All outputs are registered. Read data appears on the cycle after the read request and holds until the next accepted read.

Top module: `ppd_channel`

## Requirements
- R1: While reset is asserted and on the first cycle after it, port_data, rd_data, port_valid, ready and ready_evt are all 0.
- R2: With mode 2'b00 (output), a write stores wr_data in the output latch, shows it on port_data on the next cycle with port_valid high for that single cycle, and a read returns the output latch.
- R3: With mode 2'b01 (input), a write updates the output latch but leaves port_data unchanged and port_valid low. The new latch value becomes visible later through output-mode reads.
- R4: With mode 2'b01, a read with strobe low captures pin_data into the input latch and returns it. A read with strobe high returns the previously captured input latch and leaves it unchanged.
- R5: With mode 2'b10 (bidirectional), a write always updates the output latch. It drives port_data and pulses port_valid only when strobe is low.
- R6: A pulse request drops ready to 0 on the next cycle for exactly one cycle, and ready returns to 1 on the cycle after unless another request arrives. Pulse requests are an output-mode write, an input-mode read, and a bidirectional read or write. No other operation changes ready.
- R7: ready_evt is high for exactly the cycles in which ready differs from its value on the previous cycle.
- R8: With mode 2'b10, a read returns the input latch without sampling pin_data.
- R9: With mode 2'b11 (bit-control), a write latches and drives the byte with port_valid and no ready activity. A read captures pin_data into the input latch and returns (pin_data AND dir_mask) OR (output latch AND NOT dir_mask); a mask bit of 1 marks an input bit.
- R10: When rd_en and wr_en are high in the same cycle, only the write takes effect and rd_data keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 output, 01 input, 10 bidirectional, 11 bit-control |
| dir_mask | input | DW | Bit-control direction, 1 = input bit |
| wr_en | input | 1 | Processor data write request |
| wr_data | input | DW | Processor write data |
| rd_en | input | 1 | Processor data read request |
| rd_data | output | DW | Registered read data |
| strobe | input | 1 | Peripheral strobe, active high |
| pin_data | input | DW | Port pin levels |
| port_data | output | DW | Value driven onto the port |
| port_valid | output | 1 | One-cycle pulse when new port data is presented |
| ready | output | 1 | Handshake ready line |
| ready_evt | output | 1 | Pulse on each change of ready |

## Verification
Random sequences switch the mode on every operation and mix writes, reads, simultaneous requests and idles with random pin values, masks and strobe levels. Mode switching shows whether a latch written in one mode is correctly returned or driven in another. Strobe-high cycles in the input and bidirectional modes separate sampling and driving from their suppressed forms. Back-to-back pulse requests show whether the ready line stays low and ready_evt stays quiet when its level does not move. Random masks in bit-control mode catch a swapped or inverted merge.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
  typedef enum logic [1:0] {
    PM_OUT    = 2'b00,
    PM_IN     = 2'b01,
    PM_BIDIR  = 2'b10,
    PM_BITCTL = 2'b11
  } port_mode_e;

  // Modes and operations that cause a ready low pulse
  function automatic logic needs_ready_pulse(port_mode_e m, logic wr, logic rd);
    logic p;
    p = 1'b0;
    case (m)
      PM_OUT:   p = wr;
      PM_IN:    p = rd;
      PM_BIDIR: p = wr | rd;
      default:  p = 1'b0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/ppd_ready_ctl.sv
module ppd_ready_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_req,
  output logic ready,
  output logic ready_evt
);
  logic ready_q, ready_d;
  logic pend_q, pend_d;
  logic evt_q, evt_d;

  always_comb begin
    pend_d  = pulse_req;
    ready_d = ready_q;
    if (pulse_req)   ready_d = 1'b0;
    else if (pend_q) ready_d = 1'b1;
    evt_d = (ready_d != ready_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      pend_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      ready_q <= ready_d;
      pend_q  <= pend_d;
      evt_q   <= evt_d;
    end
  end

  assign ready     = ready_q;
  assign ready_evt = evt_q;
endmodule

// File: rtl/ppd_drive.sv
module ppd_drive
  import ppd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  port_mode_e    mode,
  input  logic          wr,
  input  logic          strobe,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] out_latch,
  output logic [DW-1:0] port_data,
  output logic          port_valid
);
  logic [DW-1:0] latch_q, port_q;
  logic          valid_q, valid_d;
  logic          drive_en;
  logic          latch_en;

  always_comb begin
    latch_en = wr;
    case (mode)
      PM_OUT:    drive_en = wr;
      PM_IN:     drive_en = 1'b0;
      PM_BIDIR:  drive_en = wr & ~strobe;
      PM_BITCTL: drive_en = wr;
      default:   drive_en = 1'b0;
    endcase
    valid_d = drive_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      port_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (latch_en) latch_q <= wr_data;
      if (drive_en) port_q  <= wr_data;
    end
  end

  assign out_latch  = latch_q;
  assign port_data  = port_q;
  assign port_valid = valid_q;
endmodule

// File: rtl/ppd_readback.sv
module ppd_readback
  import ppd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  port_mode_e    mode,
  input  logic          rd,
  input  logic          strobe,
  input  logic [DW-1:0] pin_data,
  input  logic [DW-1:0] dir_mask,
  input  logic [DW-1:0] out_latch,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] in_q, in_d;
  logic [DW-1:0] rdat_q, rdat_d;
  logic [DW-1:0] merged;
  logic          sample_en;

  // Per-bit selection between pin and output latch
  for (genvar b = 0; b < DW; b++) begin : g_merge
    assign merged[b] = dir_mask[b] ? pin_data[b] : out_latch[b];
  end

  always_comb begin
    sample_en = 1'b0;
    if (rd) begin
      case (mode)
        PM_IN:     sample_en = ~strobe;
        PM_BITCTL: sample_en = 1'b1;
        default:   sample_en = 1'b0;
      endcase
    end
    in_d   = sample_en ? pin_data : in_q;
    rdat_d = rdat_q;
    if (rd) begin
      case (mode)
        PM_OUT:    rdat_d = out_latch;
        PM_IN:     rdat_d = in_d;
        PM_BIDIR:  rdat_d = in_q;
        PM_BITCTL: rdat_d = merged;
        default:   rdat_d = rdat_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      rdat_q <= '0;
    end else begin
      in_q   <= in_d;
      rdat_q <= rdat_d;
    end
  end

  assign rd_data = rdat_q;
endmodule

// File: rtl/ppd_channel.sv
module ppd_channel
  import ppd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] dir_mask,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          strobe,
  input  logic [DW-1:0] pin_data,
  output logic [DW-1:0] port_data,
  output logic          port_valid,
  output logic          ready,
  output logic          ready_evt
);
  port_mode_e    mode_e;
  logic          rd_acc;
  logic          pulse_req;
  logic [DW-1:0] out_latch;

  assign mode_e    = port_mode_e'(mode);
  assign rd_acc    = rd_en & ~wr_en;   // write wins on collision
  assign pulse_req = needs_ready_pulse(mode_e, wr_en, rd_acc);

  ppd_ready_ctl u_ready (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_req (pulse_req),
    .ready     (ready),
    .ready_evt (ready_evt)
  );

  ppd_drive #(.DW(DW)) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_e),
    .wr         (wr_en),
    .strobe     (strobe),
    .wr_data    (wr_data),
    .out_latch  (out_latch),
    .port_data  (port_data),
    .port_valid (port_valid)
  );

  ppd_readback #(.DW(DW)) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_e),
    .rd        (rd_acc),
    .strobe    (strobe),
    .pin_data  (pin_data),
    .dir_mask  (dir_mask),
    .out_latch (out_latch),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/ppd_channel_chk.sv
module ppd_channel_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          wr_en,
  input logic          rd_en,
  input logic          strobe,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] port_data,
  input logic          port_valid,
  input logic          ready,
  input logic          ready_evt
);
  logic op_pulse;
  assign op_pulse = (mode == 2'b00 && wr_en) ||
                    (mode == 2'b01 && rd_en && !wr_en) ||
                    (mode == 2'b10 && (wr_en || rd_en));

  assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_pulse |=> !ready ##1 (ready || $past(op_pulse)));

  assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_pulse && !$past(op_pulse)) |=> $stable(ready));

  assert_evt_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ready) |-> ready_evt);

  assert_evt_only_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_evt |-> !$stable(ready));

  assert_input_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == 2'b01) |=> (!port_valid && $stable(port_data)));

  assert_bidir_strobe_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == 2'b10 && strobe) |=> (!port_valid && $stable(port_data)));

  assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    port_valid |-> ($past(wr_en) && $past(mode) != 2'b01));

  assert_collision_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> $stable(rd_data));
endmodule

bind ppd_channel ppd_channel_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .strobe     (strobe),
  .rd_data    (rd_data),
  .port_data  (port_data),
  .port_valid (port_valid),
  .ready      (ready),
  .ready_evt  (ready_evt)
);

// File: tb/sim_ppd_channel.sv
`timescale 1ns/1ps
module sim_ppd_channel;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic [DW-1:0] dir_mask, wr_data, pin_data;
  logic          wr_en, rd_en, strobe;
  logic [DW-1:0] rd_data, port_data;
  logic          port_valid, ready, ready_evt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  logic [DW-1:0] m_out, m_in, m_port, m_rd;
  logic          m_valid, m_ready, m_pend, m_evt;

  always #5 clk = ~clk;

  ppd_channel #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dir_mask(dir_mask),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .strobe(strobe), .pin_data(pin_data), .port_data(port_data),
    .port_valid(port_valid), .ready(ready), .ready_evt(ready_evt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic pulse_of(logic [1:0] m, logic w, logic r);
    return (m == 2'b00 && w) || (m == 2'b01 && r) || (m == 2'b10 && (w || r));
  endfunction

  function automatic logic [DW-1:0] merge_of(logic [DW-1:0] p, logic [DW-1:0] o, logic [DW-1:0] k);
    return (p & k) | (o & ~k);
  endfunction

  task automatic model_reset();
    m_out = '0; m_in = '0; m_port = '0; m_rd = '0;
    m_valid = 0; m_ready = 0; m_pend = 0; m_evt = 0;
  endtask

  task automatic model_step();
    logic r, nr;
    r = rd_en && !wr_en;
    m_valid = 0;
    if (r) begin
      case (mode)
        2'b00: m_rd = m_out;
        2'b01: begin if (!strobe) m_in = pin_data; m_rd = m_in; end
        2'b10: m_rd = m_in;
        default: begin m_rd = merge_of(pin_data, m_out, dir_mask); m_in = pin_data; end
      endcase
    end
    if (wr_en) begin
      if (mode != 2'b01 && !(mode == 2'b10 && strobe)) begin
        m_port = wr_data; m_valid = 1;
      end
      m_out = wr_data;
    end
    nr = pulse_of(mode, wr_en, r) ? 1'b0 : (m_pend ? 1'b1 : m_ready);
    m_evt = (nr != m_ready);
    m_ready = nr;
    m_pend = pulse_of(mode, wr_en, r);
  endtask

  task automatic compare_all();
    string rq, pq;
    rq = (wr_en && rd_en) ? "R10" : (mode == 2'b00) ? "R2" : (mode == 2'b01) ? "R4" :
         (mode == 2'b10) ? "R8" : "R9";
    pq = (mode == 2'b01) ? "R3" : (mode == 2'b10) ? "R5" : (mode == 2'b11) ? "R9" : "R2";
    chk(rq, "rd_data", rd_data, m_rd);
    chk(pq, "port_data", port_data, m_port);
    chk(pq, "port_valid", port_valid, m_valid);
    chk("R6", "ready", ready, m_ready);
    chk("R7", "ready_evt", ready_evt, m_evt);
  endtask

  task automatic op(input logic [1:0] m, input logic w, input logic r,
                    input logic [DW-1:0] d, input logic s,
                    input logic [DW-1:0] p, input logic [DW-1:0] k);
    @(negedge clk);
    mode = m; wr_en = w; rd_en = r; wr_data = d; strobe = s; pin_data = p; dir_mask = k;
    @(posedge clk);
    model_step();
    #1;
    compare_all();
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode = 2'b00; wr_en = 0; rd_en = 0; wr_data = '0;
    strobe = 0; pin_data = 8'hA5; dir_mask = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rd_data in reset", rd_data, 0);
    chk("R1", "port_data in reset", port_data, 0);
    chk("R1", "port_valid in reset", port_valid, 0);
    chk("R1", "ready in reset", ready, 0);
    chk("R1", "ready_evt in reset", ready_evt, 0);
    @(negedge clk); rst_n = 1;
    op(2'b00, 0, 0, 8'h00, 0, 8'h00, 8'h00);   // R1 first cycle after reset

    // R2 output write then read; R6 ready pulse
    op(2'b00, 1, 0, 8'h3C, 0, 8'hFF, 8'h00);
    op(2'b00, 0, 0, 8'h00, 0, 8'hFF, 8'h00);
    op(2'b00, 1, 0, 8'h81, 0, 8'hFF, 8'h00);
    op(2'b00, 0, 1, 8'h00, 0, 8'hFF, 8'h00);
    chk("R2", "read of output latch", rd_data, 8'h81);
    op(2'b00, 0, 0, 8'h00, 0, 8'hFF, 8'h00);
    chk("R6", "ready restored", ready, 1);
    // R3 input-mode write: latch only, seen by output read later
    op(2'b01, 1, 0, 8'h5A, 0, 8'h00, 8'h00);
    chk("R3", "port unchanged", port_data, 8'h81);
    op(2'b00, 0, 1, 8'h00, 0, 8'h00, 8'h00);
    chk("R3", "latch via output read", rd_data, 8'h5A);
    // R4 input read with and without strobe
    op(2'b01, 0, 1, 8'h00, 0, 8'hC3, 8'h00);
    chk("R4", "sampled pins", rd_data, 8'hC3);
    op(2'b01, 0, 1, 8'h00, 1, 8'h11, 8'h00);
    chk("R4", "strobe blocks sampling", rd_data, 8'hC3);
    // R8 bidir read returns input latch, no sampling
    op(2'b10, 0, 1, 8'h00, 0, 8'h77, 8'h00);
    chk("R8", "bidir read", rd_data, 8'hC3);
    // R5 bidir write blocked by strobe, then allowed
    op(2'b10, 1, 0, 8'hE7, 1, 8'h00, 8'h00);
    chk("R5", "blocked drive", port_data, 8'h81);
    op(2'b10, 1, 0, 8'h42, 0, 8'h00, 8'h00);
    chk("R5", "drive", port_data, 8'h42);
    // R9 bit-control write and merged read
    op(2'b11, 0, 0, 8'h00, 0, 8'h00, 8'h00);
    op(2'b11, 0, 0, 8'h00, 0, 8'h00, 8'h00);
    op(2'b11, 1, 0, 8'hF0, 0, 8'h00, 8'h00);
    chk("R9", "no ready activity", ready, 1);
    op(2'b11, 0, 1, 8'h00, 0, 8'h0F, 8'h3C);
    chk("R9", "merged read", rd_data, 8'hCC);
    // R10 collision: write wins, rd_data held
    op(2'b00, 1, 1, 8'h99, 0, 8'h00, 8'h00);
    chk("R10", "rd_data held", rd_data, 8'hCC);
    // R6/R7 back-to-back pulses
    op(2'b10, 0, 1, 8'h00, 0, 8'h00, 8'h00);
    op(2'b10, 0, 1, 8'h00, 0, 8'h00, 8'h00);
    chk("R7", "no event while held low", ready_evt, 0);
    op(2'b10, 0, 0, 8'h00, 0, 8'h00, 8'h00);

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] m;
      int k;
      m = 2'($urandom_range(0, 3));
      k = $urandom_range(0, 5);
      op(m, (k == 1 || k == 3 || k == 5), (k == 2 || k == 3 || k == 4),
         8'($urandom), ($urandom_range(0, 3) == 0), 8'($urandom), 8'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule